// File: doc/BRIEF.md
# Clock Frequency-Select Power-Up Latch

This block runs the power-up sequence of a clock generator and picks the frequency-select code the synthesizer uses. After the supply is reported good, it waits for the active-low processor power-good strobe. The strobe must stay low for a programmable number of timebase ticks. The block then captures the five frequency strap pins once. When a second tick window, counted from supply-good, has also run out, it releases the clock outputs. After the capture, no later strobe activity or strap movement changes the latched code. Only a new power cycle does.

Software gets the latched strap code back for readback. Software can also override it with its own five-bit select. A reboot input, combined with a recovery bit, chooses whether the code in force after a restart is the hardware strap value or the last software selection. The sequence walks four states in a fixed order: power off, waiting for power-good, sampling, and running.

Top module: `fsq_strap_latch`

## Requirements
- R1: While supply_ok is low, or during rst_n, clk_en is 0 and strap_code is 0. With sw_override at 0 and no recovery held, sel_code is also 0.
- R2: After power-good has been seen low (through a two-flop synchronizer) for SAMPLE_TICKS consecutive ticks, the straps are captured into strap_code, bit i holding strap pin i.
- R3: No capture takes place before the SAMPLE_TICKS-th tick of the low window. strap_code stays 0 until then.
- R4: Once captured, strap_code and clk_en hold their values no matter how the power-good strobe or the straps change, until supply_ok falls.
- R5: clk_en rises only when two conditions are both met: a capture has happened, and at least EN_TICKS ticks have passed since supply_ok went high.
- R6: If power-good never goes low, clk_en stays 0 however many ticks pass.
- R7: With sw_override at 1, sel_code equals sw_sel. With sw_override at 0, sel_code equals the base code: the strap code, or a held recovery code.
- R8: A reboot pulse with recover_sw at 0 makes the base code the latched strap code.
- R9: A reboot pulse with recover_sw at 1 holds the sel_code in force at that cycle as the base code. That value is kept after sw_override returns to 0.
- R10: If power-good returns high before the sample window is complete, the window count restarts and the next low needs a full SAMPLE_TICKS ticks.
- R11: When supply_ok falls, the block clears the one-shot state. The next power cycle captures the straps again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| supply_ok | input | 1 | Synchronous supply-good; low forces the power-off state |
| pwrgd_n | input | 1 | Asynchronous active-low processor power-good strobe |
| tick | input | 1 | One-cycle timebase pulse |
| fs_pins | input | 5 | Frequency strap pins |
| sw_sel | input | 5 | Software frequency select field |
| sw_override | input | 1 | 1 selects sw_sel as the active code |
| recover_sw | input | 1 | On reboot: 1 keeps the software code, 0 returns to straps |
| reboot | input | 1 | One-cycle reboot request |
| strap_code | output | 5 | Latched strap value for readback |
| sel_code | output | 5 | Effective frequency select code |
| clk_en | output | 1 | Clock output release |

## Verification
The bench builds the block with SAMPLE_TICKS set to 3 and EN_TICKS set to 8. These short windows make every tick count visible. They allow checking one tick before the capture and one tick before release. They also let the bench order the sample ahead of, and behind, the enable window within a few hundred cycles. With these short windows, an aborted low window, the one-shot hold while the strobe is toggled and the straps are changed, both reboot recovery choices, and a second power cycle with new straps all fit in one short run.

// File: rtl/fsq_pkg.sv
package fsq_pkg;
    localparam int unsigned FS_W = 5;
    typedef logic [FS_W-1:0] fs_code_t;
    typedef enum logic [1:0] {
        ST_OFF    = 2'd0,
        ST_WAIT   = 2'd1,
        ST_SAMPLE = 2'd2,
        ST_RUN    = 2'd3
    } seq_state_e;
endpackage

// File: rtl/fsq_sync.sv
module fsq_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain_q;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q <= RST_VAL;
                else        chain_q <= d;
            end
        end else begin : g_chain
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q <= {STAGES{RST_VAL}};
                else        chain_q <= {chain_q[STAGES-2:0], d};
            end
        end
    endgenerate

    assign q = chain_q[STAGES-1];
endmodule

// File: rtl/fsq_sequencer.sv
module fsq_sequencer
    import fsq_pkg::*;
#(
    parameter int unsigned SAMPLE_TICKS = 250,
    parameter int unsigned EN_TICKS     = 1146
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       supply_ok,
    input  logic       pg_low,
    input  logic       tick,
    input  fs_code_t   straps,
    output fs_code_t   strap_q,
    output logic       run
);
    localparam int unsigned SCW = $clog2(SAMPLE_TICKS + 1);
    localparam int unsigned ECW = $clog2(EN_TICKS + 1);

    typedef struct packed {
        seq_state_e     st;
        logic           sampled;
        logic [SCW-1:0] scnt;
        logic [ECW-1:0] ecnt;
        fs_code_t       strap;
    } regs_t;

    localparam regs_t RESET_REGS = '{
        st: ST_OFF, sampled: 1'b0, scnt: '0, ecnt: '0, strap: '0
    };

    regs_t regs_d, regs_q;
    logic  ecnt_full;

    assign ecnt_full = (regs_q.ecnt >= ECW'(EN_TICKS));

    always_comb begin
        regs_d = regs_q;
        if (!supply_ok) begin
            regs_d = RESET_REGS;
        end else begin
            unique case (regs_q.st)
                ST_OFF: begin
                    regs_d.st = ST_WAIT;
                end
                ST_WAIT: begin
                    if (tick && !ecnt_full) regs_d.ecnt = regs_q.ecnt + 1'b1;
                    if (!pg_low) begin
                        regs_d.scnt = '0;
                    end else if (tick) begin
                        if (regs_q.scnt == SCW'(SAMPLE_TICKS - 1)) begin
                            regs_d.st   = ST_SAMPLE;
                            regs_d.scnt = '0;
                        end else begin
                            regs_d.scnt = regs_q.scnt + 1'b1;
                        end
                    end
                end
                ST_SAMPLE: begin
                    if (tick && !ecnt_full) regs_d.ecnt = regs_q.ecnt + 1'b1;
                    if (!regs_q.sampled) begin
                        regs_d.strap   = straps;
                        regs_d.sampled = 1'b1;
                    end else if (ecnt_full) begin
                        regs_d.st = ST_RUN;
                    end
                end
                ST_RUN: begin
                    regs_d = regs_q;
                end
                default: regs_d = RESET_REGS;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= RESET_REGS;
        else        regs_q <= regs_d;
    end

    assign strap_q = regs_q.strap;
    assign run     = (regs_q.st == ST_RUN);
endmodule

// File: rtl/fsq_selmux.sv
module fsq_selmux
    import fsq_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     supply_ok,
    input  fs_code_t strap,
    input  fs_code_t sw_sel,
    input  logic     sw_override,
    input  logic     recover_sw,
    input  logic     reboot,
    output fs_code_t sel
);
    typedef struct packed {
        logic     kept;
        fs_code_t held;
    } hold_t;

    hold_t    hold_d, hold_q;
    fs_code_t base;

    assign base = hold_q.kept ? hold_q.held : strap;
    assign sel  = sw_override ? sw_sel : base;

    always_comb begin
        hold_d = hold_q;
        if (!supply_ok) begin
            hold_d = '0;
        end else if (reboot) begin
            hold_d.held = sel;
            hold_d.kept = recover_sw;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) hold_q <= '0;
        else        hold_q <= hold_d;
    end
endmodule

// File: rtl/fsq_strap_latch.sv
module fsq_strap_latch
    import fsq_pkg::*;
#(
    parameter int unsigned SAMPLE_TICKS = 250,
    parameter int unsigned EN_TICKS     = 1146,
    parameter int unsigned SYNC_STAGES  = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       supply_ok,
    input  logic       pwrgd_n,
    input  logic       tick,
    input  logic [4:0] fs_pins,
    input  logic [4:0] sw_sel,
    input  logic       sw_override,
    input  logic       recover_sw,
    input  logic       reboot,
    output logic [4:0] strap_code,
    output logic [4:0] sel_code,
    output logic       clk_en
);
    logic     pg_sync;
    fs_code_t strap_w;

    fsq_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_pg_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pwrgd_n),
        .q     (pg_sync)
    );

    fsq_sequencer #(.SAMPLE_TICKS(SAMPLE_TICKS), .EN_TICKS(EN_TICKS)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .supply_ok (supply_ok),
        .pg_low    (!pg_sync),
        .tick      (tick),
        .straps    (fs_pins),
        .strap_q   (strap_w),
        .run       (clk_en)
    );

    fsq_selmux u_mux (
        .clk         (clk),
        .rst_n       (rst_n),
        .supply_ok   (supply_ok),
        .strap       (strap_w),
        .sw_sel      (sw_sel),
        .sw_override (sw_override),
        .recover_sw  (recover_sw),
        .reboot      (reboot),
        .sel         (sel_code)
    );

    assign strap_code = strap_w;
endmodule

// File: rtl/fsq_strap_latch_chk.sv
module fsq_strap_latch_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       supply_ok,
    input logic       sw_override,
    input logic [4:0] sw_sel,
    input logic [4:0] strap_code,
    input logic [4:0] sel_code,
    input logic       clk_en
);
    AST_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !supply_ok |=> (!clk_en && strap_code == 5'd0)); // R1

    AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_en && supply_ok) |=> $stable(strap_code)); // R4

    AST_EN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_en && supply_ok) |=> clk_en); // R4

    AST_EN_AFTER_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(clk_en) |-> $stable(strap_code)); // R5

    AST_OVERRIDE_SEL: assert property (@(posedge clk) disable iff (!rst_n)
        sw_override |-> (sel_code == sw_sel)); // R7
endmodule

bind fsq_strap_latch fsq_strap_latch_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .supply_ok   (supply_ok),
    .sw_override (sw_override),
    .sw_sel      (sw_sel),
    .strap_code  (strap_code),
    .sel_code    (sel_code),
    .clk_en      (clk_en)
);

// File: tb/fsq_strap_latch_tb.sv
module fsq_strap_latch_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       supply_ok = 1'b0;
    logic       pwrgd_n = 1'b1;
    logic       tick = 1'b0;
    logic [4:0] fs_pins = 5'd0;
    logic [4:0] sw_sel = 5'd0;
    logic       sw_override = 1'b0;
    logic       recover_sw = 1'b0;
    logic       reboot = 1'b0;
    logic [4:0] strap_code, sel_code;
    logic       clk_en;

    int total = 0;
    int bad = 0;

    localparam int NVEC = 5;
    // {override, sw_sel, expected sel_code} with straps latched at 5'h13
    localparam logic [10:0] MUX_VEC [NVEC] = '{
        {1'b0, 5'h04, 5'h13},
        {1'b1, 5'h04, 5'h04},
        {1'b1, 5'h1F, 5'h1F},
        {1'b0, 5'h1F, 5'h13},
        {1'b1, 5'h00, 5'h00}
    };

    always #2.5 clk = ~clk;

    fsq_strap_latch #(.SAMPLE_TICKS(3), .EN_TICKS(8)) u_dut (
        .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .pwrgd_n(pwrgd_n),
        .tick(tick), .fs_pins(fs_pins), .sw_sel(sw_sel),
        .sw_override(sw_override), .recover_sw(recover_sw), .reboot(reboot),
        .strap_code(strap_code), .sel_code(sel_code), .clk_en(clk_en)
    );

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); tick = 1'b1;
            @(negedge clk); tick = 1'b0;
        end
        idle(2);
    endtask

    task automatic pulse_reboot();
        @(negedge clk); reboot = 1'b1;
        @(negedge clk); reboot = 1'b0;
    endtask

    initial begin
        idle(3);
        chk("R1 reset clk_en", clk_en, 0);
        chk("R1 reset strap", strap_code, 0);
        chk("R1 reset sel", sel_code, 0);
        rst_n = 1'b1;
        idle(4);
        chk("R1 supply low clk_en", clk_en, 0);

        supply_ok = 1'b1;
        idle(3);
        ticks(10);
        chk("R6 no power-good clk_en", clk_en, 0);
        chk("R3 no power-good strap", strap_code, 0);

        fs_pins = 5'h13;
        pwrgd_n = 1'b0;
        idle(4);
        ticks(2);
        chk("R3 before window end", strap_code, 0);
        pwrgd_n = 1'b1;
        idle(4);
        pwrgd_n = 1'b0;
        idle(4);
        ticks(2);
        chk("R10 restarted window", strap_code, 0);
        ticks(1);
        idle(2);
        chk("R2 captured straps", strap_code, 5'h13);
        chk("R5 enable after capture", clk_en, 1);

        fs_pins = 5'h0A;
        pwrgd_n = 1'b1;
        idle(4);
        ticks(4);
        pwrgd_n = 1'b0;
        idle(4);
        ticks(4);
        chk("R4 strap held", strap_code, 5'h13);
        chk("R4 clk_en held", clk_en, 1);

        for (int v = 0; v < NVEC; v++) begin
            sw_override = MUX_VEC[v][10];
            sw_sel      = MUX_VEC[v][9:5];
            idle(1);
            chk("R7 select mux", sel_code, MUX_VEC[v][4:0]);
        end

        sw_sel = 5'h07; sw_override = 1'b1; recover_sw = 1'b1;
        pulse_reboot();
        sw_override = 1'b0;
        idle(1);
        chk("R9 kept software code", sel_code, 5'h07);
        recover_sw = 1'b0;
        pulse_reboot();
        idle(1);
        chk("R8 back to strap code", sel_code, 5'h13);

        supply_ok = 1'b0;
        idle(3);
        chk("R11 off clk_en", clk_en, 0);
        chk("R11 off strap", strap_code, 0);
        chk("R1 off sel", sel_code, 0);

        supply_ok = 1'b1;
        idle(3);
        ticks(3);
        idle(2);
        chk("R11 recaptured", strap_code, 5'h0A);
        chk("R5 waits enable window", clk_en, 0);
        ticks(4);
        chk("R5 one tick short", clk_en, 0);
        ticks(1);
        idle(2);
        chk("R5 released", clk_en, 1);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #200000;
        total++;
        bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule